// File: doc/BRIEF.md
# Single-Descriptor Flash DMA Engine

This block moves data between system memory and the flash data path under the control of one buffer descriptor held in memory. Software first stores the descriptor's address in a base register. It then fills in the descriptor and hands it to the engine by setting the ownership bit. When a transfer is started, the engine reads the 16-byte descriptor through a 64-bit memory master port. It gives up at once if the descriptor still belongs to software. Otherwise it streams the buffer in whole 8-byte beats, either out toward the flash (transmit) or in from the flash (receive).

When the last beat has moved, the engine writes the descriptor's status word back with ownership returned to software. It then raises a sticky event flag for the direction that was used. Software clears a flag by writing a one to its bit position. A single descriptor describes one buffer; there is no chaining.

Top module: `bd_dma_engine`

## Requirements
- R1: After reset the engine is idle (`busy` low), all event flags read 0, and no memory request, transmit beat or receive acceptance is active.
- R2: A start pulse while idle latches the base register, with address bits 2:0 forced to 0. The engine then reads the descriptor as two 8-byte beats, at base and at base+8. In the first beat, bits 31:0 are the status word and bits 63:32 are the sizes word. In the second beat, bits 31:0 are buffer pointer 0 and bits 63:32 are buffer pointer 1.
- R3: If status bit 31 (ownership) is 0, the engine sets event bit 8 (no descriptor) and returns to idle. It moves no data and writes nothing to memory.
- R4: The beat count is sizes bits 11:0 divided by 8 and rounded up. Sizes bits 31:12 are ignored. A byte count of 0 moves no beats and still completes with a writeback.
- R5: In transmit (`xfer_dir`=0), beat i is read from pointer0+8*i, in increasing order. Each beat is presented on `tx_data` with `tx_valid` high until `tx_ready` accepts it.
- R6: In receive (`xfer_dir`=1), the i-th beat accepted on the receive stream is written to pointer0+8*i with all eight byte enables set.
- R7: Buffer pointer 1 is ignored: memory addressed by it is neither read for data nor written.
- R8: After the data, the engine writes the status word back to the latched base with bit 31 cleared and all other bits unchanged. It uses byte enables 0x0F, so the sizes word is preserved. On that write's acceptance it sets event bit 6 (transmit) or bit 7 (receive) and returns to idle.
- R9: A register write to offset 0x18 loads the base register. A write to offset 0x20 clears each event flag whose bit is 1 in the write data and leaves the others set.
- R10: A start pulse while busy is ignored. A base register write during a transfer affects only later transfers.
- R11: A memory request stays asserted with an unchanged address, direction and write data until `mem_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| evt_status | output | 32 | Event flags: bit 6 transmit done, bit 7 receive done, bit 8 no descriptor |
| xfer_start | input | 1 | Start pulse for one transfer |
| xfer_dir | input | 1 | 0 = transmit (memory to flash), 1 = receive |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Byte address, 8-byte aligned |
| mem_be | output | 8 | Byte enables for writes |
| mem_wdata | output | 64 | Memory write data |
| mem_ack | input | 1 | Request accepted this cycle; read data valid |
| mem_rdata | input | 64 | Memory read data |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Transmit beat accepted |
| tx_data | output | 64 | Transmit beat |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Receive beat accepted |
| rx_data | input | 64 | Receive beat |

## Verification
A wrong beat counter or pointer shows on the transmit stream as a missing, extra or misordered beat in the same transfer. In receive, it shows as memory words written at the wrong address before completion. A stale ownership or status register shows in the writeback word at the end of the transfer. A mistaken ownership test shows either as stream traffic where none is allowed, or as a missing bit 8 on `evt_status` one cycle after the header read. A broken latch of the base address corrupts a descriptor that software did not hand over, and is visible in memory as soon as the writeback lands.

// File: rtl/bdd_pkg.sv
package bdd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_HDR,
        ST_FETCH_PTR,
        ST_TX_READ,
        ST_TX_SEND,
        ST_RX_TAKE,
        ST_RX_WRITE,
        ST_WBACK
    } eng_state_e;

    localparam int OWN_BIT    = 31;
    localparam int FLAG_TX    = 0;
    localparam int FLAG_RX    = 1;
    localparam int FLAG_NODSC = 2;
    localparam int NUM_FLAGS  = 3;
    localparam int FLAG_LSB   = 6;

endpackage

// File: rtl/bdd_regfile.sv
module bdd_regfile
    import bdd_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int REG_AW   = 9,
    parameter int BASE_OFS = 'h18,
    parameter int CLR_OFS  = 'h20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_we_i,
    input  logic [REG_AW-1:0]    reg_addr_i,
    input  logic [31:0]          reg_wdata_i,
    input  logic [NUM_FLAGS-1:0] evt_set_i,
    output logic [ADDR_W-1:0]    base_o,
    output logic [31:0]          evt_status_o
);

    typedef struct packed {
        logic [ADDR_W-1:0]    base;
        logic [NUM_FLAGS-1:0] flags;
    } regs_t;

    regs_t rg_d, rg_q;
    logic  base_hit, clr_hit;
    logic [NUM_FLAGS-1:0] clr_mask;

    always_comb begin
        base_hit = reg_we_i && (reg_addr_i == REG_AW'(BASE_OFS));
        clr_hit  = reg_we_i && (reg_addr_i == REG_AW'(CLR_OFS));
        clr_mask = clr_hit ? reg_wdata_i[FLAG_LSB +: NUM_FLAGS] : '0;
        rg_d     = rg_q;
        if (base_hit) begin
            rg_d.base = reg_wdata_i[ADDR_W-1:0];
        end
        rg_d.flags = (rg_q.flags & ~clr_mask) | evt_set_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign base_o       = rg_q.base;
    assign evt_status_o = 32'(rg_q.flags) << FLAG_LSB;

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.flags[FLAG_TX] && !(clr_hit && reg_wdata_i[FLAG_LSB + FLAG_TX]))
        |=> rg_q.flags[FLAG_TX]);

    // R9
    rx_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.flags[FLAG_RX] && !(clr_hit && reg_wdata_i[FLAG_LSB + FLAG_RX]))
        |=> rg_q.flags[FLAG_RX]);

endmodule

// File: rtl/bdd_engine.sv
module bdd_engine
    import bdd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int SIZE_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 dir_i,
    input  logic [ADDR_W-1:0]    base_i,
    output logic                 busy_o,
    output logic [NUM_FLAGS-1:0] evt_set_o,
    output logic                 mem_req_o,
    output logic                 mem_we_o,
    output logic [ADDR_W-1:0]    mem_addr_o,
    output logic [DATA_W/8-1:0]  mem_be_o,
    output logic [DATA_W-1:0]    mem_wdata_o,
    input  logic                 mem_ack_i,
    input  logic [DATA_W-1:0]    mem_rdata_i,
    output logic                 tx_valid_o,
    input  logic                 tx_ready_i,
    output logic [DATA_W-1:0]    tx_data_o,
    input  logic                 rx_valid_i,
    output logic                 rx_ready_o,
    input  logic [DATA_W-1:0]    rx_data_i
);

    localparam int BEAT_B = DATA_W / 8;
    localparam int OFS_W  = $clog2(BEAT_B);
    localparam int CNT_W  = SIZE_W - OFS_W + 1;
    localparam logic [31:0] OWN_MASK = 32'(1) << OWN_BIT;
    localparam logic [BEAT_B-1:0] BE_ALL  = '1;
    localparam logic [BEAT_B-1:0] BE_STAT = BEAT_B'(4'hF);

    typedef struct packed {
        eng_state_e          st;
        logic                dir;
        logic [ADDR_W-1:0]   base;
        logic [31:0]         stat;
        logic [ADDR_W-1:0]   ptr;
        logic [CNT_W-1:0]    beats;
        logic [CNT_W-1:0]    idx;
        logic [DATA_W-1:0]   hold;
    } eng_t;

    eng_t e_d, e_q;

    logic [SIZE_W:0]     padded;
    logic [CNT_W-1:0]    idx_nxt;
    logic                last_beat;
    logic [ADDR_W-1:0]   beat_addr;

    always_comb begin
        padded    = {1'b0, mem_rdata_i[32 +: SIZE_W]} + (SIZE_W+1)'(BEAT_B - 1);
        idx_nxt   = e_q.idx + 1'b1;
        last_beat = (idx_nxt == e_q.beats);
        beat_addr = e_q.ptr + (ADDR_W'(e_q.idx) << OFS_W);

        e_d         = e_q;
        evt_set_o   = '0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_be_o    = '0;
        mem_wdata_o = '0;
        tx_valid_o  = 1'b0;
        tx_data_o   = e_q.hold;
        rx_ready_o  = 1'b0;

        unique case (e_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    e_d.dir  = dir_i;
                    e_d.base = {base_i[ADDR_W-1:OFS_W], OFS_W'(0)};
                    e_d.idx  = '0;
                    e_d.st   = ST_FETCH_HDR;
                end
            end
            ST_FETCH_HDR: begin
                mem_req_o  = 1'b1;
                mem_addr_o = e_q.base;
                if (mem_ack_i) begin
                    e_d.stat  = mem_rdata_i[31:0];
                    e_d.beats = padded[SIZE_W:OFS_W];
                    if (!mem_rdata_i[OWN_BIT]) begin
                        evt_set_o[FLAG_NODSC] = 1'b1;
                        e_d.st = ST_IDLE;
                    end else begin
                        e_d.st = ST_FETCH_PTR;
                    end
                end
            end
            ST_FETCH_PTR: begin
                mem_req_o  = 1'b1;
                mem_addr_o = e_q.base + ADDR_W'(BEAT_B);
                if (mem_ack_i) begin
                    e_d.ptr = {mem_rdata_i[ADDR_W-1:OFS_W], OFS_W'(0)};
                    if (e_q.beats == '0) begin
                        e_d.st = ST_WBACK;
                    end else if (e_q.dir) begin
                        e_d.st = ST_RX_TAKE;
                    end else begin
                        e_d.st = ST_TX_READ;
                    end
                end
            end
            ST_TX_READ: begin
                mem_req_o  = 1'b1;
                mem_addr_o = beat_addr;
                if (mem_ack_i) begin
                    e_d.hold = mem_rdata_i;
                    e_d.st   = ST_TX_SEND;
                end
            end
            ST_TX_SEND: begin
                tx_valid_o = 1'b1;
                if (tx_ready_i) begin
                    e_d.idx = idx_nxt;
                    e_d.st  = last_beat ? ST_WBACK : ST_TX_READ;
                end
            end
            ST_RX_TAKE: begin
                rx_ready_o = 1'b1;
                if (rx_valid_i) begin
                    e_d.hold = rx_data_i;
                    e_d.st   = ST_RX_WRITE;
                end
            end
            ST_RX_WRITE: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = beat_addr;
                mem_be_o    = BE_ALL;
                mem_wdata_o = e_q.hold;
                if (mem_ack_i) begin
                    e_d.idx = idx_nxt;
                    e_d.st  = last_beat ? ST_WBACK : ST_RX_TAKE;
                end
            end
            ST_WBACK: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = e_q.base;
                mem_be_o    = BE_STAT;
                mem_wdata_o = DATA_W'(e_q.stat & ~OWN_MASK);
                if (mem_ack_i) begin
                    evt_set_o[e_q.dir ? FLAG_RX : FLAG_TX] = 1'b1;
                    e_d.st = ST_IDLE;
                end
            end
            default: e_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign busy_o = (e_q.st != ST_IDLE);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                       && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R5
    stream_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid_o && rx_ready_o));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    // R8
    evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt_set_o));

    // R8
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !e_d.st[0] && !e_d.st[1] && !e_d.st[2] && !evt_set_o[FLAG_NODSC])
        |-> (mem_req_o && mem_we_o && mem_ack_i));

endmodule

// File: rtl/bd_dma_engine.sv
module bd_dma_engine
    import bdd_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 64,
    parameter int SIZE_W   = 12,
    parameter int REG_AW   = 9,
    parameter int BASE_OFS = 'h18,
    parameter int CLR_OFS  = 'h20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         evt_status,
    input  logic                xfer_start,
    input  logic                xfer_dir,
    output logic                busy,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                tx_valid,
    input  logic                tx_ready,
    output logic [DATA_W-1:0]   tx_data,
    input  logic                rx_valid,
    output logic                rx_ready,
    input  logic [DATA_W-1:0]   rx_data
);

    logic [ADDR_W-1:0]    base_w;
    logic [NUM_FLAGS-1:0] evt_set_w;

    bdd_regfile #(
        .ADDR_W   (ADDR_W),
        .REG_AW   (REG_AW),
        .BASE_OFS (BASE_OFS),
        .CLR_OFS  (CLR_OFS)
    ) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we_i     (reg_we),
        .reg_addr_i   (reg_addr),
        .reg_wdata_i  (reg_wdata),
        .evt_set_i    (evt_set_w),
        .base_o       (base_w),
        .evt_status_o (evt_status)
    );

    bdd_engine #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SIZE_W (SIZE_W)
    ) eng_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (xfer_start),
        .dir_i       (xfer_dir),
        .base_i      (base_w),
        .busy_o      (busy),
        .evt_set_o   (evt_set_w),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_be_o    (mem_be),
        .mem_wdata_o (mem_wdata),
        .mem_ack_i   (mem_ack),
        .mem_rdata_i (mem_rdata),
        .tx_valid_o  (tx_valid),
        .tx_ready_i  (tx_ready),
        .tx_data_o   (tx_data),
        .rx_valid_i  (rx_valid),
        .rx_ready_o  (rx_ready),
        .rx_data_i   (rx_data)
    );

    // R3
    no_traffic_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !tx_valid && !rx_ready));

endmodule

// File: tb/bd_dma_engine_tb_top.sv
module bd_dma_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] evt_status;
    logic        xfer_start = 1'b0;
    logic        xfer_dir = 1'b0;
    logic        busy;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_be;
    logic [63:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [63:0] tx_data;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [63:0] rx_data = '0;

    bd_dma_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .evt_status(evt_status), .xfer_start(xfer_start),
        .xfer_dir(xfer_dir), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_data(rx_data)
    );

    always #4ns clk = ~clk;

    logic [63:0] mem [0:255];
    logic [63:0] tx_q [$];
    logic [63:0] rx_src [$];
    logic [63:0] exp_beat;
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    logic        rx_take_pend = 1'b0;
    logic        hold_pend = 1'b0;
    logic [31:0] hold_addr = '0;
    logic [7:0]  mi;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Scoreboard monitor and memory / stream models, all at the falling edge
    always @(negedge clk) begin
        if (rx_take_pend && rx_src.size() > 0) void'(rx_src.pop_front());
        rx_valid = (rx_src.size() > 0);
        rx_data  = rx_valid ? rx_src[0] : 64'h0;
        rx_take_pend = rx_valid && rx_ready;

        tx_ready = (cyc % 3) != 1;
        if (rst_n && tx_valid && tx_ready) begin
            if (tx_q.size() == 0) begin
                check(1'b0, "R5 unexpected transmit beat", tx_data, 64'h0);
            end else begin
                exp_beat = tx_q.pop_front();
                check(tx_data == exp_beat, "R5 transmit beat", tx_data, exp_beat);
            end
        end

        if (rst_n && hold_pend)
            check(mem_req && mem_addr == hold_addr, "R11 request held",
                  {31'h0, mem_req, mem_addr}, {32'h1, hold_addr});
        mem_ack   = mem_req && ((cyc % 2) == 0);
        hold_pend = rst_n && mem_req && !mem_ack;
        hold_addr = mem_addr;
        if (mem_req) begin
            mi = mem_addr[10:3];
            mem_rdata = mem[mi];
            if (mem_ack && mem_we)
                for (int b = 0; b < 8; b++)
                    if (mem_be[b]) mem[mi][8*b +: 8] = mem_wdata[8*b +: 8];
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic reg_write(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic start_xfer(input logic dir);
        @(negedge clk);
        xfer_start = 1'b1; xfer_dir = dir;
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic put_desc(input int base, input logic [31:0] st, input logic [31:0] sz,
                            input logic [31:0] p0, input logic [31:0] p1);
        mem[base/8]     = {sz, st};
        mem[base/8 + 1] = {p1, p0};
    endtask

    // Driver: lays out a transmit buffer and pushes the expected beats
    task automatic load_tx(input int ptr, input int nbeats, input logic [15:0] tag);
        for (int i = 0; i < nbeats; i++) begin
            mem[ptr/8 + i] = {tag, 16'(i), 32'hC0DE_0000 | i};
            tx_q.push_back({tag, 16'(i), 32'hC0DE_0000 | i});
        end
    endtask

    initial begin
        logic [63:0] saved [0:3];
        logic [63:0] rxv [0:2];
        for (int i = 0; i < 256; i++) mem[i] = {32'hA5A5_0000 | i, 32'h5A5A_0000 | i};
        repeat (5) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        check(evt_status == 32'h0, "R1 flags in reset", evt_status, 0);
        check(!mem_req && !tx_valid && !rx_ready, "R1 no traffic in reset",
              {mem_req, tx_valid, rx_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && evt_status == 0, "R1 idle after reset", busy, 0);

        // Transmit of 32 bytes (4 beats)
        reg_write(9'h18, 32'h100);
        put_desc('h100, 32'h8000_000C, 32'h0000_0020, 32'h400, 32'h600);
        load_tx('h400, 4, 16'h1111);
        start_xfer(1'b0);
        wait_idle();
        check(tx_q.size() == 0, "R2 R5 all transmit beats delivered", tx_q.size(), 0);
        check(mem['h20][31:0] == 32'h0000_000C, "R8 status writeback", mem['h20][31:0], 32'hC);
        check(mem['h20][63:32] == 32'h20, "R8 sizes word kept", mem['h20][63:32], 32'h20);
        check(evt_status == 32'h40, "R8 transmit flag", evt_status, 32'h40);
        reg_write(9'h20, 32'h0);
        check(evt_status == 32'h40, "R9 zero clear keeps flag", evt_status, 32'h40);
        reg_write(9'h20, 32'h40);
        check(evt_status == 32'h0, "R9 clear transmit flag", evt_status, 0);

        // Receive of 24 bytes (3 beats), pointer 1 aimed at a separate region
        reg_write(9'h18, 32'h180);
        put_desc('h180, 32'h8000_000C, 32'h0000_0018, 32'h500, 32'h600);
        for (int i = 0; i < 3; i++) saved[i] = mem['hC0 + i];
        for (int i = 0; i < 3; i++) begin
            rxv[i] = {32'hFEED_0000 | i, 32'h1234_5600 | i};
            rx_src.push_back(rxv[i]);
        end
        start_xfer(1'b1);
        wait_idle();
        for (int i = 0; i < 3; i++)
            check(mem['hA0 + i] == rxv[i], "R6 receive beat in memory", mem['hA0 + i], rxv[i]);
        for (int i = 0; i < 3; i++)
            check(mem['hC0 + i] == saved[i], "R7 pointer1 region untouched", mem['hC0 + i], saved[i]);
        check(evt_status == 32'h80, "R8 receive flag", evt_status, 32'h80);
        check(mem['h30][31] == 1'b0, "R8 receive ownership returned", mem['h30][31], 0);
        reg_write(9'h20, 32'h80);
        check(evt_status == 32'h0, "R9 clear receive flag", evt_status, 0);

        // Descriptor still owned by software
        reg_write(9'h18, 32'h100);
        put_desc('h100, 32'h0000_000C, 32'h0000_0020, 32'h400, 32'h600);
        saved[0] = mem['h20];
        start_xfer(1'b0);
        wait_idle();
        repeat (3) @(negedge clk);
        check(evt_status == 32'h100, "R3 no-descriptor flag", evt_status, 32'h100);
        check(mem['h20] == saved[0], "R3 no writeback", mem['h20], saved[0]);
        check(tx_q.size() == 0, "R3 no data moved", tx_q.size(), 0);
        reg_write(9'h20, 32'h100);

        // 20 bytes rounds up to 3 beats; sizes bits 31:12 carry junk
        put_desc('h100, 32'h8000_000C, 32'hABCD_E014, 32'h400, 32'h600);
        load_tx('h400, 3, 16'h2222);
        start_xfer(1'b0);
        wait_idle();
        check(tx_q.size() == 0, "R4 padded beat count", tx_q.size(), 0);
        check(mem['h20][63:32] == 32'hABCD_E014, "R4 sizes high bits ignored",
              mem['h20][63:32], 32'hABCD_E014);
        reg_write(9'h20, 32'h1C0);

        // Zero byte count
        put_desc('h100, 32'h8000_000C, 32'h0000_0000, 32'h400, 32'h600);
        start_xfer(1'b0);
        wait_idle();
        check(evt_status == 32'h40, "R4 zero count completes", evt_status, 32'h40);
        check(mem['h20][31:0] == 32'h0000_000C, "R4 zero count writeback", mem['h20][31:0], 32'hC);
        reg_write(9'h20, 32'h1C0);

        // Start and base write during a busy transfer
        put_desc('h100, 32'h8000_000C, 32'h0000_0020, 32'h400, 32'h600);
        put_desc('h180, 32'h8000_000C, 32'h0000_0008, 32'h500, 32'h600);
        load_tx('h400, 4, 16'h3333);
        start_xfer(1'b0);
        repeat (3) @(negedge clk);
        start_xfer(1'b1);
        reg_write(9'h18, 32'h180);
        wait_idle();
        repeat (6) @(negedge clk);
        check(busy == 1'b0, "R10 no second transfer", busy, 0);
        check(evt_status == 32'h40, "R10 only transmit flag", evt_status, 32'h40);
        check(mem['h30][31] == 1'b1, "R10 new base not written", mem['h30][31], 1);
        check(mem['h20][31] == 1'b0, "R10 latched base written back", mem['h20][31], 0);
        check(tx_q.size() == 0, "R10 first transfer complete", tx_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule